// File: doc/BRIEF.md
# Chained-Transfer SPI Master

This block is a serial peripheral master driven through a small register interface. A configuration write stores eight mode flags, a transfer length, a clock divisor and a chip-select mask. A later 32-bit data write starts one transfer using the most recently stored settings. The block generates the serial clock, shifts the data word out, samples the return line, and drives one chip-select line per attached slave. Every pin has its own output-enable, so that the pad ring can tristate it.

Several transfers can be chained into one transaction. Chip select stays asserted from one transfer to the next and is released only after a transfer whose configuration carried the last-transfer flag. This lets software send, for example, an 8-bit command followed by a 32-bit payload under one continuous select. When the read-request flag is set, the shift register contents are presented as one read word once the transfer ends. A 3-wire mode samples the bidirectional data line instead of the separate return line.

Top module: `spi_chain_master`

## Requirements
- R1: `cfg_we` while idle stores `cfg_flags`, `cfg_len`, `cfg_div` and `cfg_cs`; a configuration write while `busy` is high is ignored. Flag bits of `cfg_flags`: bit0 offline, bit1 last transfer, bit2 read request, bit3 chip-select active level, bit4 SCK idle level, bit5 clock phase, bit6 LSB first, bit7 3-wire. After reset all flags, the length, the divisor and the mask are zero.
- R2: `dat_we` while idle loads `dat_wdata` and starts a transfer; `busy` is high from the next cycle until the transfer ends; `dat_we` while `busy` is high is ignored.
- R3: With factor F = `cfg_div` + 2 (2 to 257), one SCK period lasts exactly F system clocks: the half before each leading edge lasts ceil(F/2) clocks and the half before each trailing edge lasts floor(F/2) clocks.
- R4: A transfer produces exactly `cfg_len` + 1 SCK pulses (1 to 32 bits), and SCK rests at the idle level given by flag bit4 whenever no transfer runs.
- R5: With bit6 clear, bits leave from bit 31 of the data word downward; with bit6 set, from bit 0 upward.
- R6: With bit5 clear, input is sampled on the leading SCK edge and MOSI changes on the trailing edge (the first bit is present from the start of the transfer); with bit5 set, MOSI changes on the leading edge and input is sampled on the trailing edge.
- R7: When bit2 is set, `rd_valid` pulses once, in the cycle after the last busy cycle, with `rd_data` equal to the shift register: for n bits MSB-first, the data word shifted left by n with the received bits (first received highest) in the low n bits; LSB-first, the data word shifted right by n with the received bits (first received lowest) in the top n bits. With bit2 clear no pulse appears.
- R8: From the start of a transfer the chip selects named by the mask are driven to the active level (bit3: 1 = active high), the others to the inactive level; they stay active between chained transfers and return inactive only after a transfer with bit1 set.
- R9: With bit0 set, `sck_oe`, `mosi_oe` and `cs_oe` are all low; with it clear they are high, except as stated in R10.
- R10: With bit7 set, input is taken from `mosi_i` instead of `miso_i`, and if bit2 is also set `mosi_oe` is low so the slave can drive the shared line.
- R11: When `cfg_we` and `dat_we` arrive in the same idle cycle, the transfer uses the newly written configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_flags | input | 8 | Mode flags (see R1) |
| cfg_len | input | 5 | Transfer length in bits minus one |
| cfg_div | input | 8 | Clock factor minus two |
| cfg_cs | input | 3 | Chip-select mask, one bit per slave |
| dat_we | input | 1 | Data write strobe, starts a transfer |
| dat_wdata | input | 32 | Data word to shift out |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle read word strobe |
| rd_data | output | 32 | Read word |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| miso_i | input | 1 | Serial data in (4-wire) |
| mosi_i | input | 1 | Shared data line input (3-wire) |
| cs_o | output | 3 | Chip-select lines |
| cs_oe | output | 1 | Chip-select output enable |

## Verification
Two events can land on the same idle clock edge: a configuration write and the data write that starts a transfer. The bench drives both strobes together with a length and mask that differ from the stored ones. It judges the outcome by counting SCK pulses and decoding MOSI, both of which must follow the new configuration. The opposite collision, a data or configuration write arriving while a transfer runs, is provoked mid-transfer and judged by the shifted bits, the single read word, and the length used by the following unconfigured transfer.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

  // Mode flag word; packed so that bit 0 is offline and bit 7 is 3-wire.
  typedef struct packed {
    logic three_wire;
    logic lsb_first;
    logic cpha;
    logic cpol;
    logic cs_pol;
    logic rd_req;
    logic last;
    logic offline;
  } flags_t;

  localparam int FLAG_W = $bits(flags_t);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  output logic             tick
);

  localparam logic [DIV_W-1:0] CNT_MAX = DIV_W'(1) << (DIV_W - 1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (en && (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - DIV_W'(1);
    tick   = en && (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R3: no half period is longer than ceil(257/2) clocks
  a_r3_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lsb_first,
  input  logic              cpha,
  input  logic              lead,
  input  logic              trail,
  input  logic              din,
  output logic [DATA_W-1:0] sr,
  output logic              mosi
);

  logic [DATA_W-1:0] sr_q, sr_d, sr_nxt;
  logic              mosi_q, mosi_d;
  logic              hold_q, hold_d;
  logic              sr_en, mosi_en, hold_en;

  function automatic logic [DATA_W-1:0] shift1(input logic [DATA_W-1:0] v,
                                               input logic b, input logic lsb);
    return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
  endfunction

  function automatic logic out_bit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  always_comb begin
    sr_nxt  = shift1(sr_q, cpha ? din : hold_q, lsb_first);
    sr_en   = load || trail;
    sr_d    = load ? load_data : sr_nxt;
    hold_en = lead && !cpha;
    hold_d  = din;
    mosi_en = (load && !cpha) || (lead && cpha) || (trail && !cpha);
    if (load)      mosi_d = out_bit(load_data, lsb_first);
    else if (lead) mosi_d = out_bit(sr_q, lsb_first);
    else           mosi_d = out_bit(sr_nxt, lsb_first);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      mosi_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (sr_en)   sr_q   <= sr_d;
      if (mosi_en) mosi_q <= mosi_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign sr   = sr_q;
  assign mosi = mosi_q;

  // R6: with phase set, MOSI never moves on a trailing edge
  a_r6_phase1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cpha && trail && !load) |=> $stable(mosi_q));

  // R6: with phase clear, MOSI never moves on a leading edge
  a_r6_phase0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpha && lead && !load) |=> $stable(mosi_q));

endmodule

// File: rtl/spi_cs_unit.sv
module spi_cs_unit #(
  parameter int NCS = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           set,
  input  logic [NCS-1:0] set_mask,
  input  logic           clear,
  input  logic           cs_pol,
  input  logic           offline,
  output logic [NCS-1:0] cs,
  output logic           cs_oe
);

  logic [NCS-1:0] act_q, act_d;
  logic           act_en;

  always_comb begin
    act_en = set || clear;
    act_d  = set ? set_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs[i] = cs_pol ? act_q[i] : !act_q[i];
  end

  assign cs_oe = !offline;

  // R8: selection only changes at a transfer start or a final transfer end
  a_r8_cs_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(set || clear) |=> $stable(act_q));

endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
  import spi_chain_pkg::*;
#(
  parameter int  DATA_W = 32,
  parameter int  NCS    = 3,
  parameter int  DIV_W  = 8,
  localparam int LEN_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_flags,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [NCS-1:0]    cfg_cs,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  input  logic              mosi_i,
  output logic [NCS-1:0]    cs_o,
  output logic              cs_oe
);

  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam int FAC_W  = DIV_W + 1;

  state_e            state_q, state_d;
  flags_t            flags_q, flags_in;
  logic [LEN_W-1:0]  len_q;
  logic [DIV_W-1:0]  div_q, div_eff;
  logic [NCS-1:0]    mask_q, mask_eff;
  logic [EDGE_W-1:0] edge_q, edge_d, two_n;
  logic              sck_t_q, sck_t_d;
  logic              rd_valid_q, rd_valid_d;
  logic [DATA_W-1:0] rd_data_q;
  logic              run, cfg_take, start, tick;
  logic              edge_ev, fin_ev, lead_ev, trail_ev;
  logic              eff_lsb, eff_cpha;
  logic              tmr_load, edge_en, rd_en;
  logic [DIV_W-1:0]  tmr_val;
  logic [DATA_W-1:0] sr;
  logic              din;

  // Reload value for a half period: even halves take ceil(F/2), odd floor(F/2)
  function automatic logic [DIV_W-1:0] half_load(input logic [DIV_W-1:0] d,
                                                 input logic odd_half);
    logic [FAC_W-1:0] f;
    logic [FAC_W-1:0] h;
    f = FAC_W'(d) + FAC_W'(2);
    h = odd_half ? (f >> 1) : ((f + FAC_W'(1)) >> 1);
    return DIV_W'(h - FAC_W'(1));
  endfunction

  // Control decode
  always_comb begin
    flags_in = flags_t'(cfg_flags);
    run      = (state_q == ST_RUN);
    cfg_take = cfg_we && !run;
    start    = dat_we && !run;
    eff_lsb  = cfg_take ? flags_in.lsb_first : flags_q.lsb_first;
    eff_cpha = cfg_take ? flags_in.cpha      : flags_q.cpha;
    div_eff  = cfg_take ? cfg_div : div_q;
    mask_eff = cfg_take ? cfg_cs  : mask_q;
    two_n    = EDGE_W'({len_q, 1'b0}) + EDGE_W'(2);
    fin_ev   = run && tick && (edge_q == two_n);
    edge_ev  = run && tick && (edge_q != two_n);
    lead_ev  = edge_ev && !edge_q[0];
    trail_ev = edge_ev &&  edge_q[0];
    tmr_load = start || edge_ev;
    tmr_val  = start ? half_load(div_eff, 1'b0) : half_load(div_q, !edge_q[0]);
    din      = flags_q.three_wire ? mosi_i : miso_i;
  end

  // Next state
  always_comb begin
    state_d = state_q;
    if (start)       state_d = ST_RUN;
    else if (fin_ev) state_d = ST_IDLE;
    edge_en    = start || edge_ev;
    edge_d     = start ? '0 : edge_q + EDGE_W'(1);
    sck_t_d    = start ? 1'b0 : !sck_t_q;
    rd_en      = fin_ev && flags_q.rd_req;
    rd_valid_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      flags_q    <= '0;
      len_q      <= '0;
      div_q      <= '0;
      mask_q     <= '0;
      edge_q     <= '0;
      sck_t_q    <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      rd_valid_q <= rd_valid_d;
      if (cfg_take) begin
        flags_q <= flags_in;
        len_q   <= cfg_len;
        div_q   <= cfg_div;
        mask_q  <= cfg_cs;
      end
      if (edge_en) begin
        edge_q  <= edge_d;
        sck_t_q <= sck_t_d;
      end
      if (rd_en) rd_data_q <= sr;
    end
  end

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_data (dat_wdata),
    .lsb_first (eff_lsb),
    .cpha      (eff_cpha),
    .lead      (lead_ev),
    .trail     (trail_ev),
    .din       (din),
    .sr        (sr),
    .mosi      (mosi_o)
  );

  spi_cs_unit #(.NCS(NCS)) u_cs (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (start),
    .set_mask (mask_eff),
    .clear    (fin_ev && flags_q.last),
    .cs_pol   (flags_q.cs_pol),
    .offline  (flags_q.offline),
    .cs       (cs_o),
    .cs_oe    (cs_oe)
  );

  assign busy     = run;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign sck_o    = flags_q.cpol ^ sck_t_q;
  assign sck_oe   = !flags_q.offline;
  assign mosi_oe  = !flags_q.offline && !(flags_q.three_wire && flags_q.rd_req);

  // R1: configuration cannot change under a running transfer
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(flags_q) && $stable(len_q) && $stable(div_q)));

  // R2: a transfer stays busy until its tail half period expires
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fin_ev) |=> run);

  // R4: SCK is back at its idle level whenever no transfer runs
  a_r4_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck_t_q);

  // R4: edge count never passes two per bit
  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (edge_q <= two_n));

  // R7: a read word only follows a busy cycle
  a_r7_rd_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(run));

endmodule

// File: tb/spi_chain_master_tb.sv
module spi_chain_master_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  fl;
    logic [4:0]  lm1;
    logic [7:0]  dv;
    logic [2:0]  msk;
    logic [31:0] tx;
    logic [31:0] sw;
  } vec_t;

  // flags: 01 offline, 02 last, 04 read, 08 cs active high, 10 cpol,
  //        20 cpha, 40 lsb first, 80 3-wire
  localparam vec_t VECS [6] = '{
    '{8'h06, 5'd7,  8'd0,   3'b001, 32'h8100_0000, 32'h0000_00A5},
    '{8'h06, 5'd31, 8'd123, 3'b110, 32'hDEAD_BEEF, 32'h1234_5678},
    '{8'h7E, 5'd11, 8'd5,   3'b010, 32'h0000_0ABC, 32'h0000_0C3A},
    '{8'h86, 5'd15, 8'd1,   3'b100, 32'h1300_0000, 32'h0000_BEEF},
    '{8'h20, 5'd1,  8'd255, 3'b011, 32'hC000_0000, 32'h0000_0000},
    '{8'h16, 5'd0,  8'd2,   3'b011, 32'h8000_0000, 32'h0000_0001}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_flags = '0;
  logic [4:0]  cfg_len = '0;
  logic [7:0]  cfg_div = '0;
  logic [2:0]  cfg_cs = '0;
  logic        dat_we = 1'b0;
  logic [31:0] dat_wdata = '0;
  logic        busy, rd_valid, sck_o, sck_oe, mosi_o, mosi_oe, cs_oe;
  logic [31:0] rd_data;
  logic [2:0]  cs_o;
  logic        miso_i, mosi_i;
  logic        slave_bit = 1'b0;

  assign miso_i = slave_bit;
  assign mosi_i = mosi_oe ? mosi_o : slave_bit;

  spi_chain_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_flags(cfg_flags),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .cfg_cs(cfg_cs), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .mosi_i(mosi_i), .cs_o(cs_o), .cs_oe(cs_oe)
  );

  always #(CLK_PERIOD / 2) clk = !clk;

  int n_chk = 0;
  int n_fail = 0;

  // expectations of the transfer in flight
  logic [7:0]  cur_fl = '0;
  logic [2:0]  cur_msk = '0;
  logic [31:0] cur_sw = '0;
  int          cur_n = 1;
  int          exp_f = 2;

  // monitor state
  int          cyc = 0;
  int          lead_cnt = 0, cap_k = 0, sk = 0, per = 0, per_bad = 0;
  int          last_lead = 0, cs_bad = 0, oe_bad = 0, rd_cnt = 0;
  logic        have_lead = 1'b0, prev_sck = 1'b0, prev_busy = 1'b0;
  logic        lead_e, samp_e;
  logic [31:0] cap = '0, rd_last = '0;

  function automatic logic sbit(int k);
    if (k >= cur_n) return 1'b0;
    return cur_fl[6] ? cur_sw[k] : cur_sw[cur_n - 1 - k];
  endfunction

  function automatic logic [2:0] cs_level(logic [2:0] m, logic pol);
    return pol ? m : ~m;
  endfunction

  function automatic logic [31:0] exp_mosi(logic [31:0] tx, int n, logic lsb);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    return lsb ? 32'(64'(tx) & m) : (tx >> (32 - n));
  endfunction

  function automatic logic [31:0] exp_rd(logic [31:0] tx, logic [31:0] sw, int n, logic lsb);
    logic [63:0] m = (64'd1 << n) - 64'd1;
    if (!lsb) return 32'((64'(tx) << n) | (64'(sw) & m));
    return (tx >> n) | 32'((64'(sw) & m) << (32 - n));
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // slave model and bus monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (busy && !prev_busy) begin
      lead_cnt = 0; cap = '0; cap_k = 0; sk = 0; per = 0; per_bad = 0;
      have_lead = 1'b0; cs_bad = 0; oe_bad = 0; rd_cnt = 0;
      if (!cur_fl[5]) begin
        slave_bit = sbit(0);
        sk = 1;
      end
    end else if (busy && (sck_o != prev_sck)) begin
      lead_e = (prev_sck == cur_fl[4]);
      if (lead_e) begin
        lead_cnt++;
        if (have_lead) begin
          per = cyc - last_lead;
          if (per != exp_f) per_bad++;
        end
        last_lead = cyc;
        have_lead = 1'b1;
      end
      samp_e = cur_fl[5] ? !lead_e : lead_e;
      if (samp_e) begin
        if (cur_fl[6]) begin
          if (cap_k < 32) cap[cap_k] = mosi_o;
        end else begin
          cap = {cap[30:0], mosi_o};
        end
        cap_k++;
      end else begin
        slave_bit = sbit(sk);
        sk++;
      end
    end
    if (busy) begin
      if (cs_o !== cs_level(cur_msk, cur_fl[3])) cs_bad++;
      if (cur_fl[7] && cur_fl[2] && mosi_oe) oe_bad++;
    end
    if (rd_valid) begin
      rd_cnt++;
      rd_last = rd_data;
    end
    prev_sck  = sck_o;
    prev_busy = busy;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_cfg(input logic [7:0] fl, input logic [4:0] lm1,
                        input logic [7:0] dv, input logic [2:0] msk);
    cfg_flags = fl; cfg_len = lm1; cfg_div = dv; cfg_cs = msk; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_start(input logic [31:0] d);
    dat_wdata = d; dat_we = 1'b1;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_expect(input logic [7:0] fl, input int lm1, input int dv,
                            input logic [2:0] msk, input logic [31:0] sw);
    cur_fl = fl; cur_n = lm1 + 1; exp_f = dv + 2; cur_msk = msk; cur_sw = sw;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    set_expect(v.fl, int'(v.lm1), int'(v.dv), v.msk, v.sw);
    do_cfg(v.fl, v.lm1, v.dv, v.msk);
    do_start(v.tx);
    wait_idle();
    $display("vector %0d", idx);
    check("R4 pulse count", 32'(lead_cnt), 32'(cur_n));
    check("R4 idle level", {31'd0, sck_o}, {31'd0, v.fl[4]});
    if (cur_n > 1) begin
      check("R3 period", 32'(per), 32'(exp_f));
      check("R3 period steady", 32'(per_bad), 32'd0);
    end
    if (!(v.fl[7] && v.fl[2]))
      check("R5 R6 MOSI bits", cap, exp_mosi(v.tx, cur_n, v.fl[6]));
    check("R7 read pulses", 32'(rd_cnt), {31'd0, v.fl[2]});
    if (v.fl[2])
      check("R7 read word", rd_last, exp_rd(v.tx, v.sw, cur_n, v.fl[6]));
    check("R8 cs during", 32'(cs_bad), 32'd0);
    check("R8 cs after", {29'd0, cs_o},
          {29'd0, cs_level(v.fl[1] ? 3'b000 : v.msk, v.fl[3])});
    if (v.fl[7] && v.fl[2]) check("R10 line released", 32'(oe_bad), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    check("R7 reset rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R4 reset sck", {31'd0, sck_o}, 32'd0);
    check("R8 reset cs inactive", {29'd0, cs_o}, 32'd7);
    check("R9 reset enables", {29'd0, sck_oe, mosi_oe, cs_oe}, 32'd7);

    // table walk
    for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

    // R9: offline tristates every output, clearing it restores them
    do_cfg(8'h01, 5'd7, 8'd0, 3'b001);
    @(negedge clk);
    check("R9 offline enables", {29'd0, sck_oe, mosi_oe, cs_oe}, 32'd0);
    do_cfg(8'h06, 5'd7, 8'd0, 3'b001);
    @(negedge clk);
    check("R9 online enables", {29'd0, sck_oe, mosi_oe, cs_oe}, 32'd7);

    // R2 / R1: writes during a transfer are ignored
    set_expect(8'h06, 7, 9, 3'b001, 32'h0000_003C);
    do_cfg(8'h06, 5'd7, 8'd9, 3'b001);
    do_start(32'hA500_0000);
    check("R2 busy after start", {31'd0, busy}, 32'd1);
    repeat (3) @(negedge clk);
    cfg_flags = 8'h00; cfg_len = 5'd3; cfg_div = 8'd0; cfg_cs = 3'b100;
    dat_wdata = 32'h5A00_0000; cfg_we = 1'b1; dat_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; dat_we = 1'b0;
    wait_idle();
    check("R2 first data kept", cap, 32'h0000_00A5);
    check("R2 single read", 32'(rd_cnt), 32'd1);
    repeat (4) @(negedge clk);
    check("R2 no second start", {31'd0, busy}, 32'd0);
    do_start(32'hF000_0000);
    wait_idle();
    check("R1 length kept", 32'(lead_cnt), 32'd8);
    check("R1 read flag kept", 32'(rd_cnt), 32'd1);

    // R11: configuration and data in the same cycle
    set_expect(8'h06, 3, 0, 3'b100, 32'h0000_0006);
    cfg_flags = 8'h06; cfg_len = 5'd3; cfg_div = 8'd0; cfg_cs = 3'b100;
    dat_wdata = 32'h9000_0000; cfg_we = 1'b1; dat_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; dat_we = 1'b0;
    wait_idle();
    check("R11 new length", 32'(lead_cnt), 32'd4);
    check("R11 new bits", cap, 32'h0000_0009);
    check("R11 new mask", 32'(cs_bad), 32'd0);
    check("R11 read word", rd_last, 32'h0000_0006);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule